// File: doc/BRIEF.md
# Operand Bypass Selector for a Five-Stage Integer Pipeline

This block chooses where the execute stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) takes its operands from. For each cycle it compares the source registers of the instruction in execute with the destinations of the two older instructions held in the execute/memory and memory/writeback latches. It then drives a mux select for each ALU operand. Each select picks the register-file value, the execute/memory result or the memory/writeback result. When both older instructions write the same register, the younger one, which sits in execute/memory, wins.

A second select steers the store-data input at the memory stage. A store directly behind a load can take the loaded word from the memory/writeback latch, so no stall is needed. The register file writes in the first half of a cycle and reads in the second half. An instruction three places ahead therefore needs no bypass. Writes happen only in writeback, so only read-after-write dependences are handled. The block is purely combinational. Stall generation, the register file and branch resolution are outside it.

Top module: `fwd_unit`

## Requirements
- R1: Instruction words carry the first source register in bits 25:21 and the second in bits 20:16. The destination sits in bits 15:11 for class ALU_R (code 0) and in bits 20:16 for ALU_I (1) and LOAD (2). STORE (3), BRANCH (4) and NOP (5) write no register. When the execute/memory entry writes the first source register, opASel is 2'b10.
- R2: When only the memory/writeback entry writes a source register, that operand's select is 2'b01.
- R3: When both latch entries write the same source register, the select is 2'b10, because the younger producer wins.
- R4: opBSel follows the rules of R1 to R3 on the second source register only when the execute class is ALU_R, STORE or BRANCH. For every other class it is 2'b00.
- R5: A destination of register 0 never matches, so the select stays 2'b00 (register file).
- R6: A latch entry whose write enable is low, or whose class writes no register, never matches. With no producer in either latch, including a producer three instructions ahead, both selects are 2'b00 and storeDataSel is 0.
- R7: storeDataSel is 1 when all of these hold: the memory-stage class is STORE, the writeback class is LOAD, the writeback write enable is high, and the load's destination equals the store's bits 20:16 and is nonzero.
- R8: storeDataSel is 0 when the writeback producer is not a LOAD, even if it writes the store's data register, or when the memory-stage instruction is not a STORE.
- R9: When the execute class is NOP, both operand selects are 2'b00 whatever the latches hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exInstr | input | 32 | Instruction word in execute |
| exClass | input | 3 | Class code of the execute instruction |
| memInstr | input | 32 | Instruction word in the execute/memory latch |
| memClass | input | 3 | Class code of the execute/memory instruction |
| memRegWe | input | 1 | Register write enable in the execute/memory latch |
| wbInstr | input | 32 | Instruction word in the memory/writeback latch |
| wbClass | input | 3 | Class code of the memory/writeback instruction |
| wbRegWe | input | 1 | Register write enable in the memory/writeback latch |
| opASel | output | 2 | First ALU operand select: 00 register file, 10 execute/memory, 01 memory/writeback |
| opBSel | output | 2 | Second ALU operand select, same encoding |
| storeDataSel | output | 1 | 1 selects the loaded word for the memory-stage store data |

## Verification
The hardest cases to reach are the ones where a match looks present but must be rejected. Examples are a store or branch whose bits 20:16 happen to equal a source register, an immediate-class instruction in execute whose bits 20:16 collide with a producer, and a non-load writeback that targets the store's data register. The stimulus builds these on purpose by filling unused fields with the colliding register number. A sweep over all 32 register numbers, with both latches active, then covers every priority combination, including register 0.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [2:0] {
    CLS_ALU_R  = 3'd0,
    CLS_ALU_I  = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_NOP    = 3'd5
  } instrClassT;

  localparam logic [1:0] SEL_REGFILE = 2'b00;
  localparam logic [1:0] SEL_EXMEM   = 2'b10;
  localparam logic [1:0] SEL_MEMWB   = 2'b01;

  // Match strobes handed from the datapath to the control.
  typedef struct packed {
    logic memRs;
    logic memRt;
    logic wbRs;
    logic wbRt;
    logic wbStore;
  } hitT;

  function automatic logic writesRd(input instrClassT c);
    return c == CLS_ALU_R;
  endfunction

  function automatic logic writesRt(input instrClassT c);
    return (c == CLS_ALU_I) || (c == CLS_LOAD);
  endfunction

  function automatic logic readsRt(input instrClassT c);
    return (c == CLS_ALU_R) || (c == CLS_STORE) || (c == CLS_BRANCH);
  endfunction

endpackage

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int REG_W   = 5,
  parameter int RS_LSB  = 21,
  parameter int RT_LSB  = 16,
  parameter int RD_LSB  = 11
) (
  input  logic [INSTR_W-1:0] exInstr,
  input  logic [INSTR_W-1:0] memInstr,
  input  instrClassT         memCls,
  input  logic               memRegWe,
  input  logic [INSTR_W-1:0] wbInstr,
  input  instrClassT         wbCls,
  input  logic               wbRegWe,
  output hitT                hits
);

  localparam int NUM_PROD = 2;   // 0: execute/memory, 1: memory/writeback
  localparam int WB_IDX   = NUM_PROD - 1;

  logic [REG_W-1:0] exRs, exRt, memRt;
  assign exRs  = exInstr[RS_LSB +: REG_W];
  assign exRt  = exInstr[RT_LSB +: REG_W];
  assign memRt = memInstr[RT_LSB +: REG_W];

  logic [NUM_PROD-1:0][INSTR_W-1:0] prodInstr;
  instrClassT                       prodCls [NUM_PROD];
  logic [NUM_PROD-1:0]              prodWe;
  logic [NUM_PROD-1:0][REG_W-1:0]   prodDst;
  logic [NUM_PROD-1:0]              prodLive;
  logic [NUM_PROD-1:0]              rsHit, rtHit;

  assign prodInstr[0] = memInstr;
  assign prodInstr[1] = wbInstr;
  assign prodCls[0]   = memCls;
  assign prodCls[1]   = wbCls;
  assign prodWe[0]    = memRegWe;
  assign prodWe[1]    = wbRegWe;

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    always_comb begin
      prodDst[p]  = writesRd(prodCls[p]) ? prodInstr[p][RD_LSB +: REG_W]
                                         : prodInstr[p][RT_LSB +: REG_W];
      prodLive[p] = prodWe[p]
                    && (writesRd(prodCls[p]) || writesRt(prodCls[p]))
                    && (prodDst[p] != '0);
    end
    assign rsHit[p] = prodLive[p] && (prodDst[p] == exRs);
    assign rtHit[p] = prodLive[p] && (prodDst[p] == exRt);
  end

  always_comb begin
    hits.memRs   = rsHit[0];
    hits.memRt   = rtHit[0];
    hits.wbRs    = rsHit[WB_IDX];
    hits.wbRt    = rtHit[WB_IDX];
    hits.wbStore = prodLive[WB_IDX] && (prodDst[WB_IDX] == memRt);
  end

  always_comb begin
    if (hits.memRs || hits.wbRs) begin
      assert_no_zero_match_R5: assert (exRs != '0);
    end
    if (hits.memRs || hits.memRt) begin
      assert_mem_enabled_R6: assert (memRegWe && memCls != CLS_STORE && memCls != CLS_BRANCH);
    end
  end

endmodule

// File: rtl/fwd_control.sv
module fwd_control
  import fwd_pkg::*;
(
  input  hitT        hits,
  input  instrClassT exCls,
  input  instrClassT memCls,
  input  instrClassT wbCls,
  output logic [1:0] opASel,
  output logic [1:0] opBSel,
  output logic       storeDataSel
);

  always_comb begin
    opASel = SEL_REGFILE;
    opBSel = SEL_REGFILE;
    if (exCls != CLS_NOP) begin
      // Younger producer first.
      if (hits.memRs)     opASel = SEL_EXMEM;
      else if (hits.wbRs) opASel = SEL_MEMWB;
    end
    if (readsRt(exCls)) begin
      if (hits.memRt)     opBSel = SEL_EXMEM;
      else if (hits.wbRt) opBSel = SEL_MEMWB;
    end
    storeDataSel = hits.wbStore && (memCls == CLS_STORE) && (wbCls == CLS_LOAD);
  end

  always_comb begin
    if (opBSel != SEL_REGFILE) begin
      assert_b_needs_rt_R4: assert (exCls == CLS_ALU_R || exCls == CLS_STORE || exCls == CLS_BRANCH);
    end
    if (opASel == SEL_MEMWB) begin
      assert_young_first_R3: assert (!hits.memRs);
    end
    if (exCls == CLS_NOP) begin
      assert_nop_quiet_R9: assert (opASel == SEL_REGFILE && opBSel == SEL_REGFILE);
    end
    if (storeDataSel) begin
      assert_store_from_load_R7: assert (hits.wbStore && wbCls == CLS_LOAD);
    end
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int REG_W   = 5,
  parameter int RS_LSB  = 21,
  parameter int RT_LSB  = 16,
  parameter int RD_LSB  = 11
) (
  input  logic [INSTR_W-1:0] exInstr,
  input  logic [2:0]         exClass,
  input  logic [INSTR_W-1:0] memInstr,
  input  logic [2:0]         memClass,
  input  logic               memRegWe,
  input  logic [INSTR_W-1:0] wbInstr,
  input  logic [2:0]         wbClass,
  input  logic               wbRegWe,
  output logic [1:0]         opASel,
  output logic [1:0]         opBSel,
  output logic               storeDataSel
);

  instrClassT exCls, memCls, wbCls;
  assign exCls  = instrClassT'(exClass);
  assign memCls = instrClassT'(memClass);
  assign wbCls  = instrClassT'(wbClass);

  hitT hits;

  fwd_datapath #(
    .INSTR_W(INSTR_W), .REG_W(REG_W),
    .RS_LSB(RS_LSB), .RT_LSB(RT_LSB), .RD_LSB(RD_LSB)
  ) u_dp (
    .exInstr (exInstr),
    .memInstr(memInstr),
    .memCls  (memCls),
    .memRegWe(memRegWe),
    .wbInstr (wbInstr),
    .wbCls   (wbCls),
    .wbRegWe (wbRegWe),
    .hits    (hits)
  );

  fwd_control u_ctl (
    .hits        (hits),
    .exCls       (exCls),
    .memCls      (memCls),
    .wbCls       (wbCls),
    .opASel      (opASel),
    .opBSel      (opBSel),
    .storeDataSel(storeDataSel)
  );

endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;

  localparam logic [2:0] C_R = 3'd0, C_I = 3'd1, C_LD = 3'd2, C_ST = 3'd3, C_BR = 3'd4, C_NOP = 3'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] exInstr, memInstr, wbInstr;
  logic [2:0]  exClass, memClass, wbClass;
  logic        memRegWe, wbRegWe;
  logic [1:0]  opASel, opBSel;
  logic        storeDataSel;

  fwd_unit dut (
    .exInstr(exInstr), .exClass(exClass),
    .memInstr(memInstr), .memClass(memClass), .memRegWe(memRegWe),
    .wbInstr(wbInstr), .wbClass(wbClass), .wbRegWe(wbRegWe),
    .opASel(opASel), .opBSel(opBSel), .storeDataSel(storeDataSel)
  );

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       s;
    string      tag;
  } expT;

  expT scoreQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  function automatic logic [31:0] mkR(input int rs, input int rt, input int rd);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 11'd0};
  endfunction

  function automatic logic [31:0] mkI(input int rs, input int rt);
    return {6'h23, rs[4:0], rt[4:0], 16'h0040};
  endfunction

  // Destination as the requirements define it; 0 means none.
  function automatic int dstOf(input logic [31:0] w, input logic [2:0] c, input logic we);
    int d;
    if (!we) return 0;
    if (c == C_R) d = int'(w[15:11]);
    else if (c == C_I || c == C_LD) d = int'(w[20:16]);
    else d = 0;
    return d;
  endfunction

  task automatic apply(input logic [31:0] ei, input logic [2:0] ec,
                       input logic [31:0] mi, input logic [2:0] mc, input logic mw,
                       input logic [31:0] wi, input logic [2:0] wc, input logic ww,
                       input string tag);
    expT e;
    int md, wd, rs, rt;
    @(posedge clk);
    #1;
    exInstr = ei; exClass = ec; memInstr = mi; memClass = mc; memRegWe = mw;
    wbInstr = wi; wbClass = wc; wbRegWe = ww;
    md = dstOf(mi, mc, mw);
    wd = dstOf(wi, wc, ww);
    rs = int'(ei[25:21]);
    rt = int'(ei[20:16]);
    e.a = 2'b00; e.b = 2'b00;
    if (ec != C_NOP) begin
      if (md != 0 && md == rs) e.a = 2'b10;
      else if (wd != 0 && wd == rs) e.a = 2'b01;
    end
    if (ec == C_R || ec == C_ST || ec == C_BR) begin
      if (md != 0 && md == rt) e.b = 2'b10;
      else if (wd != 0 && wd == rt) e.b = 2'b01;
    end
    e.s = (mc == C_ST) && (wc == C_LD) && ww && (int'(wi[20:16]) != 0)
          && (wi[20:16] == mi[20:16]);
    e.tag = tag;
    scoreQ.push_back(e);
  endtask

  // Monitor: compares at the falling edge, away from the driving edge.
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      expT e;
      e = scoreQ.pop_front();
      nChecks++;
      if (opASel !== e.a || opBSel !== e.b || storeDataSel !== e.s) begin
        nFails++;
        $display("FAIL %s: got a=%b b=%b s=%b expected a=%b b=%b s=%b",
                 e.tag, opASel, opBSel, storeDataSel, e.a, e.b, e.s);
      end
    end
  end

  initial begin
    exInstr = '0; memInstr = '0; wbInstr = '0;
    exClass = C_NOP; memClass = C_NOP; wbClass = C_NOP;
    memRegWe = 0; wbRegWe = 0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R6 reset/idle state: nothing in flight
    apply(mkR(0,0,0), C_NOP, '0, C_NOP, 0, '0, C_NOP, 0, "R6 idle");
    // R1 execute/memory producer feeds operand A
    apply(mkR(3,4,6), C_R, mkR(1,2,3), C_R, 1, '0, C_NOP, 0, "R1 exmem to A");
    // R2 memory/writeback producer feeds operand B
    apply(mkR(7,4,6), C_R, mkR(1,2,9), C_R, 1, mkI(1,4), C_I, 1, "R2 memwb to B");
    // R3 both latches write reg 5
    apply(mkR(5,5,6), C_R, mkI(2,5), C_I, 1, mkR(1,2,5), C_R, 1, "R3 younger wins");
    // R5 destination register 0
    apply(mkR(0,0,6), C_R, mkR(1,2,0), C_R, 1, mkI(3,0), C_LD, 1, "R5 reg zero");
    // R6 write enable low in execute/memory, writeback still matches
    apply(mkR(8,2,6), C_R, mkR(1,2,8), C_R, 0, mkR(1,2,8), C_R, 1, "R6 disabled exmem");
    // R6 store and branch in latches write nothing even with enable high
    apply(mkR(7,7,6), C_R, mkR(1,7,7), C_ST, 1, mkR(7,7,7), C_BR, 1, "R6 no-dest classes");
    // R6 producer three ahead: already out of both latches
    apply(mkR(4,4,6), C_R, mkR(1,2,9), C_R, 1, mkR(1,2,10), C_R, 1, "R6 three ahead");
    // R4 immediate class does not read bits 20:16
    apply(mkI(1,12), C_I, mkR(1,2,12), C_R, 1, '0, C_NOP, 0, "R4 imm no B");
    apply(mkI(1,12), C_LD, mkR(1,2,12), C_R, 1, '0, C_NOP, 0, "R4 load no B");
    // R4 store and branch do read bits 20:16
    apply(mkI(1,12), C_ST, mkR(1,2,12), C_R, 1, '0, C_NOP, 0, "R4 store B");
    apply(mkI(12,13), C_BR, mkR(1,2,12), C_R, 1, mkI(1,13), C_LD, 1, "R4 branch A and B");
    // R9 NOP in execute
    apply(mkR(3,3,0), C_NOP, mkR(1,2,3), C_R, 1, mkI(1,3), C_I, 1, "R9 nop");
    // R7 load then store to same register
    apply(mkR(1,1,1), C_NOP, mkI(2,9), C_ST, 0, mkI(4,9), C_LD, 1, "R7 load to store");
    // R8 writeback is an ALU op writing the store's register
    apply(mkR(1,1,1), C_NOP, mkI(2,9), C_ST, 0, mkR(1,2,9), C_R, 1, "R8 alu not load");
    apply(mkR(1,1,1), C_NOP, mkI(2,9), C_ST, 0, mkI(4,9), C_I, 1, "R8 imm not load");
    // R8 memory stage is not a store
    apply(mkR(1,1,1), C_NOP, mkI(2,9), C_LD, 1, mkI(4,9), C_LD, 1, "R8 mem not store");
    // R7 boundary: load to reg 0, load disabled, different register
    apply(mkR(1,1,1), C_NOP, mkI(2,0), C_ST, 0, mkI(4,0), C_LD, 1, "R7 reg zero");
    apply(mkR(1,1,1), C_NOP, mkI(2,9), C_ST, 0, mkI(4,9), C_LD, 0, "R7 load disabled");
    apply(mkR(1,1,1), C_NOP, mkI(2,9), C_ST, 0, mkI(4,10), C_LD, 1, "R7 other reg");

    // R1 R2 R3 R5 sweep of every register number
    for (int r = 0; r < 32; r++) begin
      apply(mkR(r, 31 - r, 1), C_R, mkR(1, 2, 7), C_R, 1, mkI(3, r), C_LD, 1, "R1/R2 sweep");
      apply(mkR(r, r, 1), C_R, mkR(1, 2, r), C_R, 1, mkR(4, 5, r), C_R, 1, "R3 sweep");
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule